// File: doc/BRIEF.md
# Paged Program Counter Unit

This block owns the instruction address of a small 8-bit controller core. It keeps a 13-bit program counter and a 5-bit upper-address latch. Every cycle it chooses one source for the next counter value. The choices are sequential increment, a jump or call carrying an 11-bit immediate, a software write of the counter's low byte, a return carrying a full 13-bit address from an external stack, and synchronous reset. Decode, the ALU, program memory and the return stack sit outside this block. The block only decides which source wins and builds the resulting address.

The upper counter bits can never be written directly. They are taken from the latch, and how many latch bits are used depends on the load type. A low-byte write takes all five latch bits. A jump or call takes only the two page bits. A return takes none, because the popped address is already complete. A computed jump adds an offset to the low byte outside this block and delivers the sum as a low-byte write. Because of this, an offset that crosses a 256-word boundary does not carry into the upper bits.

Top module: `pc_paged_unit`

## Requirements
- R1: With `rst` high at a clock edge, the counter becomes 0x0000 and the latch becomes 0 after that edge, regardless of every other input.
- R2: `lo_rd_o` always equals bits [7:0] of `pc_o`.
- R3: A low-byte write loads `pc_o[7:0]` from `lo_wr_data` and `pc_o[12:8]` from latch bits [4:0]. No carry or other value from the old counter reaches bits [12:8].
- R4: A jump or call loads `pc_o[10:0]` from `jmp_tgt` and `pc_o[12:11]` from latch bits [4:3].
- R5: A return loads all 13 bits of `pc_o` from `ret_addr`, whatever the latch holds.
- R6: When several strobes are active in one cycle, the winner is chosen in this order: reset, then return, then jump, then low-byte write, then increment.
- R7: An increment with no higher-priority strobe adds one to the counter, and 0x1FFF wraps to 0x0000.
- R8: The latch changes only at an edge where `lat_wr_en` is high, and then takes `lat_wr_data`. Returns, jumps and low-byte writes never alter it. A load in the same cycle as a latch write uses the latch value from before that write.
- R9: With no strobe active, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inc_en | input | 1 | Sequential increment request |
| jmp_en | input | 1 | Jump or call strobe |
| jmp_tgt | input | 11 | Immediate target from the instruction |
| lo_wr_en | input | 1 | Low-byte write strobe |
| lo_wr_data | input | 8 | Value written to the low byte |
| ret_en | input | 1 | Return strobe (plain, literal, or from interrupt) |
| ret_addr | input | 13 | Address popped from the return stack |
| lat_wr_en | input | 1 | Upper-address latch write strobe |
| lat_wr_data | input | 5 | Value written to the latch |
| pc_o | output | 13 | Current program counter |
| lo_rd_o | output | 8 | Readback of the counter's low byte |

## Verification
The collision that matters most is a latch write arriving in the same cycle as a load that reads the latch. The bench pairs a latch write with a low-byte write, and separately with a jump. It expects the address to carry the old upper bits, and expects the new bits to appear only on the next load. The second collision stacks return, jump, low-byte write and increment in one cycle, then drops the top strobe each time. Each result must come from exactly the winner named by the priority order. Reset is also asserted together with a return to show that reset wins.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Source chosen for the next program counter value
    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_INC  = 3'd1,
        SRC_LOW  = 3'd2,
        SRC_JMP  = 3'd3,
        SRC_RET  = 3'd4,
        SRC_RST  = 3'd5
    } pc_src_e;

endpackage

// File: rtl/pcu_arb.sv
module pcu_arb
    import pcu_pkg::*;
(
    input  logic    rst,
    input  logic    ret_en,
    input  logic    jmp_en,
    input  logic    lo_wr_en,
    input  logic    inc_en,
    output pc_src_e src
);

    // Fixed priority: reset, return, jump, low-byte write, increment
    always_comb begin
        if (rst)           src = SRC_RST;
        else if (ret_en)   src = SRC_RET;
        else if (jmp_en)   src = SRC_JMP;
        else if (lo_wr_en) src = SRC_LOW;
        else if (inc_en)   src = SRC_INC;
        else               src = SRC_HOLD;
    end

endmodule

// File: rtl/pcu_addr.sv
module pcu_addr
    import pcu_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int IMM_W = 11,
    localparam int HI_W   = PC_W - LO_W,
    localparam int PAGE_W = PC_W - IMM_W
) (
    input  pc_src_e           src,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [HI_W-1:0]   lat_cur,
    input  logic [IMM_W-1:0]  jmp_tgt,
    input  logic [LO_W-1:0]   lo_wr_data,
    input  logic [PC_W-1:0]   ret_addr,
    output logic [PC_W-1:0]   pc_nxt
);

    logic [PAGE_W-1:0] page_bits;
    logic [PC_W-1:0]   pc_inc;

    // Page bits are the top PAGE_W bits of the latch
    assign page_bits = lat_cur[HI_W-1 -: PAGE_W];
    // Natural modulo-2^PC_W wrap
    assign pc_inc    = pc_cur + {{(PC_W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (src)
            SRC_RST:  pc_nxt = '0;
            SRC_RET:  pc_nxt = ret_addr;
            SRC_JMP:  pc_nxt = {page_bits, jmp_tgt};
            SRC_LOW:  pc_nxt = {lat_cur, lo_wr_data};
            SRC_INC:  pc_nxt = pc_inc;
            default:  pc_nxt = pc_cur;
        endcase
    end

endmodule

// File: rtl/pc_paged_unit.sv
module pc_paged_unit
    import pcu_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int IMM_W = 11,
    localparam int HI_W = PC_W - LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_en,
    input  logic              jmp_en,
    input  logic [IMM_W-1:0]  jmp_tgt,
    input  logic              lo_wr_en,
    input  logic [LO_W-1:0]   lo_wr_data,
    input  logic              ret_en,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic              lat_wr_en,
    input  logic [HI_W-1:0]   lat_wr_data,
    output logic [PC_W-1:0]   pc_o,
    output logic [LO_W-1:0]   lo_rd_o
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [HI_W-1:0] lat;
    } pcu_state_t;

    pcu_state_t      st_d, st_q;
    pc_src_e         src;
    logic [PC_W-1:0] pc_nxt;
    logic [HI_W-1:0] lat_q;

    assign lat_q = st_q.lat;

    pcu_arb u_arb (
        .rst      (rst),
        .ret_en   (ret_en),
        .jmp_en   (jmp_en),
        .lo_wr_en (lo_wr_en),
        .inc_en   (inc_en),
        .src      (src)
    );

    pcu_addr #(
        .PC_W  (PC_W),
        .LO_W  (LO_W),
        .IMM_W (IMM_W)
    ) u_addr (
        .src        (src),
        .pc_cur     (st_q.pc),
        .lat_cur    (st_q.lat),
        .jmp_tgt    (jmp_tgt),
        .lo_wr_data (lo_wr_data),
        .ret_addr   (ret_addr),
        .pc_nxt     (pc_nxt)
    );

    // Next-state process
    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_nxt;
        if (rst)            st_d.lat = '0;
        else if (lat_wr_en) st_d.lat = lat_wr_data;
    end

    // State register
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o    = st_q.pc;
    assign lo_rd_o = st_q.pc[LO_W-1:0];

endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int IMM_W = 11,
    localparam int HI_W   = PC_W - LO_W,
    localparam int PAGE_W = PC_W - IMM_W
) (
    input logic              clk,
    input logic              rst,
    input logic              inc_en,
    input logic              jmp_en,
    input logic [IMM_W-1:0]  jmp_tgt,
    input logic              lo_wr_en,
    input logic [LO_W-1:0]   lo_wr_data,
    input logic              ret_en,
    input logic [PC_W-1:0]   ret_addr,
    input logic              lat_wr_en,
    input logic [HI_W-1:0]   lat_wr_data,
    input logic [PC_W-1:0]   pc_o,
    input logic [HI_W-1:0]   lat_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && lat_q == '0));

    // R5
    ret_load_chk: assert property (@(posedge clk) disable iff (rst)
        ret_en |=> pc_o == $past(ret_addr));

    // R4
    jmp_page_chk: assert property (@(posedge clk) disable iff (rst)
        (!ret_en && jmp_en) |=>
            (pc_o[IMM_W-1:0] == $past(jmp_tgt) &&
             pc_o[PC_W-1:IMM_W] == $past(lat_q[HI_W-1 -: PAGE_W])));

    // R3
    low_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!ret_en && !jmp_en && lo_wr_en) |=>
            (pc_o == {$past(lat_q), $past(lo_wr_data)}));

    // R7
    inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!ret_en && !jmp_en && !lo_wr_en && inc_en && (&pc_o)) |=>
            pc_o == '0);

    // R8
    latch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lat_wr_en |=> $stable(lat_q));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ret_en && !jmp_en && !lo_wr_en && !inc_en) |=> $stable(pc_o));

endmodule

bind pc_paged_unit pcu_chk #(
    .PC_W  (PC_W),
    .LO_W  (LO_W),
    .IMM_W (IMM_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .inc_en      (inc_en),
    .jmp_en      (jmp_en),
    .jmp_tgt     (jmp_tgt),
    .lo_wr_en    (lo_wr_en),
    .lo_wr_data  (lo_wr_data),
    .ret_en      (ret_en),
    .ret_addr    (ret_addr),
    .lat_wr_en   (lat_wr_en),
    .lat_wr_data (lat_wr_data),
    .pc_o        (pc_o),
    .lat_q       (lat_q)
);

// File: tb/tb_pc_paged_unit.sv
module tb_pc_paged_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inc_en = 1'b0, jmp_en = 1'b0, lo_wr_en = 1'b0;
    logic        ret_en = 1'b0, lat_wr_en = 1'b0;
    logic [10:0] jmp_tgt = '0;
    logic [7:0]  lo_wr_data = '0;
    logic [12:0] ret_addr = '0;
    logic [4:0]  lat_wr_data = '0;
    logic [12:0] pc_o;
    logic [7:0]  lo_rd_o;

    int checks = 0;
    int errors = 0;

    logic [12:0] m_pc  = '0;
    logic [4:0]  m_lat = '0;
    logic [12:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    pc_paged_unit dut (
        .clk(clk), .rst(rst), .inc_en(inc_en), .jmp_en(jmp_en),
        .jmp_tgt(jmp_tgt), .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
        .ret_en(ret_en), .ret_addr(ret_addr), .lat_wr_en(lat_wr_en),
        .lat_wr_data(lat_wr_data), .pc_o(pc_o), .lo_rd_o(lo_rd_o)
    );

    // Driver: applies one cycle of stimulus and queues the expected result
    task automatic drive(input logic r, input logic rt, input logic [12:0] ra,
                         input logic j, input logic [10:0] t,
                         input logic l, input logic [7:0] d,
                         input logic i, input logic lw, input logic [4:0] ld,
                         input string tag);
        logic [12:0] nxt;
        @(negedge clk);
        rst = r; ret_en = rt; ret_addr = ra; jmp_en = j; jmp_tgt = t;
        lo_wr_en = l; lo_wr_data = d; inc_en = i; lat_wr_en = lw; lat_wr_data = ld;
        if (r)       nxt = 13'h0000;
        else if (rt) nxt = ra;
        else if (j)  nxt = {m_lat[4:3], t};
        else if (l)  nxt = {m_lat, d};
        else if (i)  nxt = m_pc + 13'd1;
        else         nxt = m_pc;
        if (r)       m_lat = 5'h00;
        else if (lw) m_lat = ld;
        m_pc = nxt;
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        drive(0, 0, 13'h0, 0, 11'h0, 0, 8'h0, 0, 0, 5'h0, tag);
    endtask

    // Monitor: compares one result after every edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [12:0] e;
                string       tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if (pc_o !== e) begin
                    errors++;
                    $display("FAIL %s: pc_o actual %h expected %h", tg, pc_o, e);
                end
                checks++;
                if (lo_rd_o !== e[7:0]) begin
                    errors++;
                    $display("FAIL R2 (%s): lo_rd_o actual %h expected %h", tg, lo_rd_o, e[7:0]);
                end
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        drive(1, 0, 13'h0, 0, 11'h0, 0, 8'h0, 0, 0, 5'h0, "R1 reset");
        drive(1, 0, 13'h0, 0, 11'h0, 0, 8'h0, 1, 0, 5'h0, "R1 reset over inc");
        // R9 latch write only, counter holds
        drive(0, 0, 13'h0, 0, 11'h0, 0, 8'h0, 0, 1, 5'h1F, "R9 hold during latch write");
        // R3 low write takes all latch bits
        drive(0, 0, 13'h0, 0, 11'h0, 1, 8'hFF, 0, 0, 5'h0, "R3 low write full latch");
        // R7 wrap and step
        drive(0, 0, 13'h0, 0, 11'h0, 0, 8'h0, 1, 0, 5'h0, "R7 wrap 1FFF");
        drive(0, 0, 13'h0, 0, 11'h0, 0, 8'h0, 1, 0, 5'h0, "R7 increment");
        // R8 latch write same cycle as low write: old latch used
        drive(0, 0, 13'h0, 0, 11'h0, 1, 8'h10, 0, 1, 5'h02, "R8 low write uses old latch");
        // R4 jump with page bits 00
        drive(0, 0, 13'h0, 1, 11'h7FF, 0, 8'h0, 0, 0, 5'h0, "R4 jump page 0");
        // R8 latch write same cycle as jump
        drive(0, 0, 13'h0, 1, 11'h123, 0, 8'h0, 0, 1, 5'h0A, "R8 jump uses old latch");
        drive(0, 0, 13'h0, 1, 11'h123, 0, 8'h0, 0, 0, 5'h0, "R4 jump page 1");
        // R3 computed jump: truncated sum, no carry into upper bits
        drive(0, 0, 13'h0, 0, 11'h0, 1, 8'hFE, 0, 0, 5'h0, "R3 table base");
        drive(0, 0, 13'h0, 0, 11'h0, 1, 8'h02, 0, 0, 5'h0, "R3 no carry on wrapped sum");
        // R6 / R5 return wins over everything but reset
        drive(0, 1, 13'h1234, 1, 11'h055, 1, 8'h66, 1, 0, 5'h0, "R6 return wins");
        // R5 / R8 latch untouched by return
        drive(0, 0, 13'h0, 0, 11'h0, 1, 8'h00, 0, 0, 5'h0, "R8 latch kept after return");
        drive(0, 1, 13'h1ABC, 0, 11'h0, 0, 8'h0, 0, 0, 5'h0, "R5 return full address");
        // R6 jump beats low write and increment
        drive(0, 0, 13'h0, 1, 11'h0F0, 1, 8'h77, 1, 0, 5'h0, "R6 jump wins");
        // R6 low write beats increment
        drive(0, 0, 13'h0, 0, 11'h0, 1, 8'h44, 1, 0, 5'h0, "R6 low write wins");
        // R9 idle hold
        idle("R9 idle hold");
        idle("R9 idle hold 2");
        // R1 reset beats return and clears latch
        drive(1, 1, 13'h1555, 0, 11'h0, 0, 8'h0, 0, 0, 5'h0, "R1 reset beats return");
        drive(0, 0, 13'h0, 0, 11'h0, 1, 8'h33, 0, 0, 5'h0, "R1 latch cleared");
        idle("R9 final");
        @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule